// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the serial master side of a station management link toward one or more external Ethernet PHYs. A host-side controller presents a single command: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word, and pulses `start_i`. The block then produces the whole management frame on its clock pin and its bidirectional data pin. It builds MDC from the system clock, drives or releases MDIO bit by bit, samples the PHY's reply on reads, checks that the PHY took over the line during turnaround, and pulses `done_o` when the frame has ended.

The optional run of 32 one bits at the head of a frame can be left out for PHYs that accept frames without it. The MDC rate is chosen per frame from 2.5, 5 or 10 MHz. The rate select and the command are captured when the frame starts, so the inputs may change while a frame is running. The pad driver is outside the block: `mdio_o` carries the value and `mdio_oe_o` enables the driver.

Top module: `mdio_master`

## Requirements
- R1: While no frame is running, `mdc_o` is 0, `mdio_oe_o` is 0 and `busy_o` is 0; this is also the state after reset.
- R2: With preamble enabled (`no_preamble_i` = 0), a frame has 65 bit times in this order: 32 driven ones, start bits 0 then 1, then the opcode, which is 1,0 for a read (`op_read_i` = 1) and 0,1 for a write.
- R3: With `no_preamble_i` = 1, the frame begins directly with the start bits and lasts 33 bit times.
- R4: After the opcode, the PHY address and then the register address are sent, 5 bits each, most significant bit first.
- R5: On a write, the two turnaround bit times carry a driven 1 then a driven 0, followed by the 16 data bits of `wr_data_i`, most significant bit first.
- R6: On a read, `mdio_oe_o` is 0 for both turnaround bit times and all 16 data bit times; `mdio_i` is sampled at each rising MDC edge of the data field and assembled MSB first into `rd_data_o`.
- R7: On a read, `rd_err_o` is set when `mdio_i` is not 0 at the rising MDC edge of the second turnaround bit; it is cleared when any frame starts, so a write or a read that sees 0 leaves it at 0.
- R8: The last bit time of a frame releases MDIO; `done_o` is then a single-cycle pulse in the cycle that MDC returns to 0 and `busy_o` falls.
- R9: Each bit time is one low phase of MDC followed by one high phase, each phase lasting CLK_FREQ_KHZ/(2·f) system cycles, where `rate_sel_i` 00 gives f = 2500 kHz, 01 gives 5000 kHz, 10 gives 10000 kHz and 11 gives 2500 kHz.
- R10: MDIO value and enable change only when MDC falls (or at frame start), never while MDC is high; `rate_sel_i` and the command inputs are captured at frame start, and later changes do not affect the running frame.
- R11: A `start_i` pulse while `busy_o` is 1 is ignored: no second frame follows and the running frame is unchanged.
- R12: A start request with `phy_addr_i` = 1Fh is refused: no frame runs, `busy_o` stays 0 and `done_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a frame |
| op_read_i | input | 1 | 1 for a read frame, 0 for a write frame |
| no_preamble_i | input | 1 | 1 omits the 32-bit preamble |
| rate_sel_i | input | 2 | MDC rate choice: 00 and 11 slow, 01 medium, 10 fast |
| phy_addr_i | input | 5 | Target PHY address (1Fh is refused) |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Data to write |
| mdio_i | input | 1 | Value seen on the MDIO pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO when enabled |
| mdio_oe_o | output | 1 | MDIO driver enable |
| busy_o | output | 1 | A frame is running |
| done_o | output | 1 | One-cycle pulse at frame end |
| rd_data_o | output | 16 | Data from the last read |
| rd_err_o | output | 1 | Last read saw no PHY drive in turnaround |

## Verification
The bench goes after the turnaround in both directions: a PHY model that stays silent must raise the error flag, a present one must not, and a design that sampled the first turnaround bit or drove the line during a read would show up as a wrong flag or a wrong drive-enable pattern. Frames with and without preamble and at all four rate codes are timed cycle for cycle, so a miscounted divider, a wrong code mapping or a rate taken live instead of latched changes the measured length. A second start during a frame and a start toward address 1Fh are applied; a design that accepted either would produce an extra frame or done pulse that the scoreboard has no entry for.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdio_state_e;

    localparam int unsigned POS_W = 7;

    // Bit positions inside a full-length frame; a frame without preamble
    // starts at POS_START.
    localparam logic [POS_W-1:0] POS_FIRST = 7'd0;
    localparam logic [POS_W-1:0] POS_START = 7'd32;
    localparam logic [POS_W-1:0] POS_TA2   = 7'd47;
    localparam logic [POS_W-1:0] POS_DATA  = 7'd48;
    localparam logic [POS_W-1:0] POS_IDLE  = 7'd64;

    localparam logic [4:0] PHY_RESERVED = 5'h1F;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             tick_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             last;

    assign last   = (cnt_q == (half_i - ONE));
    assign tick_o = run_i && last;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mdio_bit_map.sv
module mdio_bit_map
    import mdio_pkg::*;
(
    input  mdio_cmd_t        cmd_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o,
    output logic             drive_o
);

    // Both vectors are laid out with position 0 at the most significant end.
    logic [64:0] val_vec;
    logic [64:0] oe_vec;
    logic [1:0]  opcode;
    logic [1:0]  ta_bits;
    logic [POS_W-1:0] idx;

    always_comb begin
        opcode  = cmd_i.rd ? 2'b10 : 2'b01;
        ta_bits = cmd_i.rd ? 2'b00 : 2'b10;
        val_vec = {32'hFFFF_FFFF, 2'b01, opcode, cmd_i.phy, cmd_i.regad,
                   ta_bits, cmd_i.wdata, 1'b0};
        oe_vec  = {{46{1'b1}}, {18{~cmd_i.rd}}, 1'b0};
        idx     = POS_IDLE - pos_i;
        bit_o   = val_vec[idx];
        drive_o = oe_vec[idx];
    end

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned HALF_SLOW = 40,
    parameter int unsigned HALF_MID  = 20,
    parameter int unsigned HALF_FAST = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_read_i,
    input  logic             no_preamble_i,
    input  logic [1:0]       rate_sel_i,
    input  logic [4:0]       phy_addr_i,
    input  logic [4:0]       reg_addr_i,
    input  logic [15:0]      wr_data_i,
    input  logic             mdio_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic [CNT_W-1:0] half_o,
    output mdio_cmd_t        cmd_o,
    output logic [POS_W-1:0] pos_o,
    output logic             mdc_o,
    output logic             done_o,
    output logic [15:0]      rd_data_o,
    output logic             rd_err_o
);

    typedef struct packed {
        mdio_state_e      state;
        logic [POS_W-1:0] pos;
        mdio_cmd_t        cmd;
        logic [CNT_W-1:0] half;
        logic             mdc;
        logic             done;
        logic [15:0]      rdsh;
        logic             err;
    } ctrl_t;

    localparam logic [POS_W-1:0] POS_ONE = {{(POS_W-1){1'b0}}, 1'b1};

    ctrl_t q, d;
    logic  accept;
    logic [CNT_W-1:0] half_sel;

    always_comb begin
        case (rate_sel_i)
            2'b01:   half_sel = CNT_W'(HALF_MID);
            2'b10:   half_sel = CNT_W'(HALF_FAST);
            default: half_sel = CNT_W'(HALF_SLOW);
        endcase
    end

    assign accept = start_i && (phy_addr_i != PHY_RESERVED);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.state     = ST_RUN;
                    d.pos       = no_preamble_i ? POS_START : POS_FIRST;
                    d.cmd.rd    = op_read_i;
                    d.cmd.phy   = phy_addr_i;
                    d.cmd.regad = reg_addr_i;
                    d.cmd.wdata = wr_data_i;
                    d.half      = half_sel;
                    d.mdc       = 1'b0;
                    d.err       = 1'b0;
                end
            end
            ST_RUN: begin
                if (tick_i) begin
                    if (!q.mdc) begin
                        // rising MDC: sample the PHY on reads
                        d.mdc = 1'b1;
                        if (q.cmd.rd) begin
                            if (q.pos == POS_TA2) begin
                                d.err = (mdio_i != 1'b0);
                            end
                            if ((q.pos >= POS_DATA) && (q.pos < POS_IDLE)) begin
                                d.rdsh = {q.rdsh[14:0], mdio_i};
                            end
                        end
                    end else begin
                        // falling MDC: move to the next bit time
                        d.mdc = 1'b0;
                        if (q.pos == POS_IDLE) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.pos = q.pos + POS_ONE;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, pos: '0, cmd: '0, half: CNT_W'(HALF_SLOW),
                   mdc: 1'b0, done: 1'b0, rdsh: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign run_o     = (q.state == ST_RUN);
    assign half_o    = q.half;
    assign cmd_o     = q.cmd;
    assign pos_o     = q.pos;
    assign mdc_o     = q.mdc;
    assign done_o    = q.done;
    assign rd_data_o = q.rdsh;
    assign rd_err_o  = q.err;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned CLK_FREQ_KHZ = 200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        op_read_i,
    input  logic        no_preamble_i,
    input  logic [1:0]  rate_sel_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic        mdio_i,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rd_data_o,
    output logic        rd_err_o
);

    localparam int unsigned HALF_SLOW = CLK_FREQ_KHZ / (2 * 2500);
    localparam int unsigned HALF_MID  = CLK_FREQ_KHZ / (2 * 5000);
    localparam int unsigned HALF_FAST = CLK_FREQ_KHZ / (2 * 10000);
    localparam int unsigned CNT_W     = $clog2(HALF_SLOW + 1);

    logic             run;
    logic             tick;
    logic [CNT_W-1:0] half;
    mdio_cmd_t        cmd;
    logic [POS_W-1:0] pos;
    logic             bit_val;
    logic             bit_drv;

    mdio_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (half),
        .tick_o (tick)
    );

    mdio_frame_ctrl #(
        .CNT_W     (CNT_W),
        .HALF_SLOW (HALF_SLOW),
        .HALF_MID  (HALF_MID),
        .HALF_FAST (HALF_FAST)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .op_read_i     (op_read_i),
        .no_preamble_i (no_preamble_i),
        .rate_sel_i    (rate_sel_i),
        .phy_addr_i    (phy_addr_i),
        .reg_addr_i    (reg_addr_i),
        .wr_data_i     (wr_data_i),
        .mdio_i        (mdio_i),
        .tick_i        (tick),
        .run_o         (run),
        .half_o        (half),
        .cmd_o         (cmd),
        .pos_o         (pos),
        .mdc_o         (mdc_o),
        .done_o        (done_o),
        .rd_data_o     (rd_data_o),
        .rd_err_o      (rd_err_o)
    );

    mdio_bit_map u_map (
        .cmd_i   (cmd),
        .pos_i   (pos),
        .bit_o   (bit_val),
        .drive_o (bit_drv)
    );

    assign busy_o    = run;
    assign mdio_oe_o = run && bit_drv;
    assign mdio_o    = mdio_oe_o && bit_val;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [4:0] phy_addr_i,
    input logic       mdc_o,
    input logic       mdio_o,
    input logic       mdio_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       rd_err_o
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));

    a_r10_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !mdc_o && $past(busy_o)));

    a_r12_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (phy_addr_i == 5'h1F)) |=> !busy_o);

    a_r7_err_set_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err_o) |-> busy_o);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .phy_addr_i (phy_addr_i),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_err_o   (rd_err_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

    localparam int CLK_KHZ = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_read_i = 1'b0;
    logic        no_preamble_i = 1'b0;
    logic [1:0]  rate_sel_i = 2'b00;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mdio_i = 1'b1;
    logic        mdc_o, mdio_o, mdio_oe_o, busy_o, done_o, rd_err_o;
    logic [15:0] rd_data_o;

    always #2.5ns clk = ~clk;

    mdio_master #(.CLK_FREQ_KHZ(CLK_KHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_read_i(op_read_i),
        .no_preamble_i(no_preamble_i), .rate_sel_i(rate_sel_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
        .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
        .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o), .rd_err_o(rd_err_o)
    );

    typedef struct {
        logic [64:0] val;
        logic [64:0] oe;
        int          first;
        int          cycles;
        bit          rd;
        bit          chk_rd;
        logic [15:0] rdv;
        bit          err;
        bit          phy_on;
        logic [15:0] phy_word;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] rs);
        case (rs)
            2'b01:   return CLK_KHZ / 10000;
            2'b10:   return CLK_KHZ / 20000;
            default: return CLK_KHZ / 5000;
        endcase
    endfunction

    // Expected frame, indexed by bit position (0..64 of a full frame).
    function automatic exp_t build(input bit rd, input bit nopre, input logic [1:0] rs,
                                   input logic [4:0] phy, input logic [4:0] rg,
                                   input logic [15:0] dat);
        exp_t e;
        e.val = '0;
        e.oe  = '0;
        for (int p = 0; p < 32; p++) e.val[p] = 1'b1;
        e.val[32] = 1'b0;
        e.val[33] = 1'b1;
        e.val[34] = rd;
        e.val[35] = !rd;
        for (int i = 0; i < 5; i++) e.val[36+i] = phy[4-i];
        for (int i = 0; i < 5; i++) e.val[41+i] = rg[4-i];
        e.val[46] = !rd;
        e.val[47] = 1'b0;
        for (int i = 0; i < 16; i++) e.val[48+i] = rd ? 1'b0 : dat[15-i];
        for (int p = 0; p < 46; p++) e.oe[p] = 1'b1;
        for (int p = 46; p < 64; p++) e.oe[p] = !rd;
        e.oe[64] = 1'b0;
        e.first  = nopre ? 32 : 0;
        e.cycles = 2 * half_of(rs) * (65 - e.first);
        e.rd     = rd;
        return e;
    endfunction

    // Monitor and PHY model, both at the falling system clock edge.
    int          rises = 0;
    int          cyc = 0;
    int          cur_first = 0;
    logic [64:0] ov = '0;
    logic [64:0] oo = '0;
    logic        prev_mdc = 1'b0;
    logic        prev_busy = 1'b0;
    logic        prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk(!done_o, "R8", "done pulse width", {64'd0, done_o}, 65'd0);
            end
            if (busy_o && !prev_busy) begin
                rises = 0;
                cyc   = 0;
                ov    = '0;
                oo    = '0;
                cur_first = (sbq.size() != 0) ? sbq[0].first : 0;
            end
            if (busy_o) cyc++;
            if (mdc_o && !prev_mdc) begin
                ov[cur_first + rises] = mdio_o;
                oo[cur_first + rises] = mdio_oe_o;
                rises++;
            end
            if (!mdc_o && prev_mdc && busy_o) begin
                int p;
                p = cur_first + rises;
                mdio_i = 1'b1;
                if ((sbq.size() != 0) && sbq[0].rd && sbq[0].phy_on) begin
                    if (p == 47) mdio_i = 1'b0;
                    else if (p >= 48 && p <= 63) mdio_i = sbq[0].phy_word[63-p];
                end
            end
            if (done_o) begin
                mdio_i = 1'b1;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R11 or R12", "unexpected frame end", 65'd1, 65'd0);
                end else begin
                    exp_t e;
                    logic [64:0] m;
                    e = sbq.pop_front();
                    m = {65{1'b1}} << e.first;
                    chk((ov & e.oe & m) == (e.val & e.oe & m), e.tag, "driven bits",
                        ov & e.oe & m, e.val & e.oe & m);
                    chk((oo & m) == (e.oe & m), "R6 R8", "drive enable per bit",
                        oo & m, e.oe & m);
                    chk(cyc == e.cycles, "R9", "frame length in cycles",
                        65'(cyc), 65'(e.cycles));
                    chk(rd_err_o == e.err, "R7", "read error flag",
                        {64'd0, rd_err_o}, {64'd0, e.err});
                    if (e.chk_rd) begin
                        chk(rd_data_o == e.rdv, "R6", "read data",
                            {49'd0, rd_data_o}, {49'd0, e.rdv});
                    end
                    chk(!mdc_o, "R8", "MDC low at done", {64'd0, mdc_o}, 65'd0);
                end
            end
        end
        prev_mdc  = mdc_o;
        prev_busy = busy_o;
        prev_done = done_o;
    end

    // Driver: pushes the expected item, then issues the command.
    task automatic send(input bit rd, input bit nopre, input logic [1:0] rs,
                        input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] dat, input bit phy_on,
                        input logic [15:0] word, input bit disturb,
                        input string tag);
        exp_t e;
        e = build(rd, nopre, rs, phy, rg, dat);
        e.phy_on   = phy_on;
        e.phy_word = word;
        e.chk_rd   = rd && phy_on;
        e.rdv      = word;
        e.err      = rd && !phy_on;
        e.tag      = tag;
        sbq.push_back(e);
        @(negedge clk);
        op_read_i     = rd;
        no_preamble_i = nopre;
        rate_sel_i    = rs;
        phy_addr_i    = phy;
        reg_addr_i    = rg;
        wr_data_i     = dat;
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            repeat (300) @(negedge clk);
            // R10: new rate and command inputs mid-frame; R11: second start
            rate_sel_i    = 2'b10;
            op_read_i     = !rd;
            phy_addr_i    = 5'h03;
            wr_data_i     = 16'h0F0F;
            no_preamble_i = !nopre;
            start_i       = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(!busy_o, "R11", "no second frame after done", {64'd0, busy_o}, 65'd0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: quiet after reset
        chk(!mdc_o, "R1", "MDC after reset", {64'd0, mdc_o}, 65'd0);
        chk(!mdio_oe_o, "R1", "MDIO enable after reset", {64'd0, mdio_oe_o}, 65'd0);
        chk(!busy_o, "R1", "busy after reset", {64'd0, busy_o}, 65'd0);

        send(1'b0, 1'b0, 2'b00, 5'h05, 5'h0A, 16'hA5C3, 1'b0, 16'h0000, 1'b0, "R2 R4 R5");
        send(1'b1, 1'b0, 2'b01, 5'h12, 5'h01, 16'h0000, 1'b1, 16'h3C96, 1'b0, "R2 R4");
        send(1'b1, 1'b1, 2'b10, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h0000, 1'b0, "R3 R4");
        send(1'b0, 1'b1, 2'b11, 5'h1E, 5'h10, 16'h8001, 1'b0, 16'h0000, 1'b0, "R3 R5");
        send(1'b1, 1'b1, 2'b00, 5'h09, 5'h06, 16'h0000, 1'b1, 16'hF00D, 1'b1, "R3 R10");
        send(1'b0, 1'b0, 2'b10, 5'h11, 5'h15, 16'h5AA5, 1'b0, 16'h0000, 1'b1, "R2 R5 R10");

        // R12: reserved PHY address refused
        @(negedge clk);
        op_read_i  = 1'b1;
        phy_addr_i = 5'h1F;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy_o || mdc_o) begin
                chk(1'b0, "R12", "frame started for address 1Fh",
                    {63'd0, busy_o, mdc_o}, 65'd0);
                break;
            end
        end
        chk(!busy_o && !mdc_o, "R12", "idle after refused start",
            {63'd0, busy_o, mdc_o}, 65'd0);
        chk(!mdio_oe_o, "R1", "MDIO released when idle", {64'd0, mdio_oe_o}, 65'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R8", "watchdog: frame never completed", 65'd0, 65'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule